// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a processor register port and the shift engine of a serial controller. It holds two byte queues of 64 entries each. The processor loads bytes for sending into the transmit queue, and the shift engine takes them out in order. The shift engine stores each received byte in the receive queue, and the processor reads them back. The processor can read how full each queue is from one level word. It can empty either queue with a strobe in a control word.

Three events are recorded in a sticky status word: the receive queue reaching three-quarters full, the transmit queue falling to three-quarters empty, and the shift engine reporting the end of a transfer. Each status bit is cleared by writing a 1 to it. An enable word at the same bit positions selects which recorded events drive the single interrupt line. Software uses the thresholds to refill or drain the queues in bursts, without polling byte by byte.

Top module: `fifo_irq_hub`

## Requirements
- R1: Each queue holds up to 64 bytes and returns them in the order they were written. The level word reports the receive count in bits 6:0 and the transmit count in bits 22:16, and all its other bits read 0.
- R2: A write to a queue that holds 64 bytes is dropped, and the count stays at 64.
- R3: A read from an empty queue returns 0 and leaves the count at 0.
- R4: A control write with bit 8 set empties the transmit queue, and one with bit 9 set empties the receive queue. The other queue and all other control bits have no effect.
- R5: Status bit 4 is set in the cycle after the receive count rises from below 48 to 48 or more.
- R6: Status bit 12 is set in the cycle after the transmit count falls from above 16 to 16 or less. The empty transmit queue after reset does not set it.
- R7: Status bit 16 is set in the cycle after the transfer-done input rises. Holding the input high sets the bit only once.
- R8: A status bit stays set until a status write with a 1 in that position clears it. It stays cleared while its condition remains true. Writing all ones clears every pending bit. A new event in the same cycle as a clear leaves the bit set.
- R9: The enable word keeps only bits 4, 12 and 16, and reads 0 elsewhere. The interrupt output is high exactly when some status bit is set together with its enable bit.
- R10: After reset both queues are empty, and the status word, the enable word and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word; bit 8 empties transmit, bit 9 empties receive |
| ien_we | input | 1 | Enable word write strobe |
| ien_wdata | input | 32 | Enable word write data |
| ien_rdata | output | 32 | Enable word read value |
| sts_we | input | 1 | Status clear strobe |
| sts_wdata | input | 32 | Status clear mask, write 1 to clear |
| sts_rdata | output | 32 | Sticky status word |
| lvl_rdata | output | 32 | Queue level word |
| cpu_tx_push | input | 1 | Processor writes a byte to the transmit queue |
| cpu_tx_byte | input | 8 | Byte to transmit |
| cpu_rx_pop | input | 1 | Processor takes a byte from the receive queue |
| cpu_rx_byte | output | 8 | Receive queue head, 0 when empty |
| sh_tx_pop | input | 1 | Shift engine takes a byte from the transmit queue |
| sh_tx_byte | output | 8 | Transmit queue head, 0 when empty |
| sh_rx_push | input | 1 | Shift engine stores a received byte |
| sh_rx_byte | input | 8 | Received byte |
| sh_xfer_done | input | 1 | Transfer-done level from the shift engine |
| irq | output | 1 | Combined interrupt request |

## Verification
The queues are loaded with distinct byte values, and a scoreboard compares every byte taken out, so reordering, duplication or loss of a byte shows up. A 65-byte burst into an empty transmit queue shows whether the byte offered while full is dropped. Reads from empty queues show whether 0 is returned and the count is left alone. The receive count is stepped to 47 and then to 48, and the transmit count is stepped to 17 and then to 16, which places the edge-triggered thresholds exactly on their boundaries. The done input is held high, cleared while still high, and pulsed together with a clear, which separates level behaviour from edge behaviour and shows which of set and clear wins.

// File: rtl/fqi_pkg.sv
package fqi_pkg;
  localparam int REG_W       = 32;
  localparam int NUM_EVT     = 3;
  // event index order inside the block
  localparam int EVT_RX      = 0;
  localparam int EVT_TX      = 1;
  localparam int EVT_DONE    = 2;
  // bit positions in the status and enable words
  localparam int POS_RX      = 4;
  localparam int POS_TX      = 12;
  localparam int POS_DONE    = 16;
  // control strobes
  localparam int CTL_TX_CLR  = 8;
  localparam int CTL_RX_CLR  = 9;
  // level word field offsets
  localparam int LVL_RX_LSB  = 0;
  localparam int LVL_TX_LSB  = 16;

  function automatic int evt_pos(input int idx);
    case (idx)
      EVT_RX:  evt_pos = POS_RX;
      EVT_TX:  evt_pos = POS_TX;
      default: evt_pos = POS_DONE;
    endcase
  endfunction
endpackage

// File: rtl/fqi_byte_fifo.sv
module fqi_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty, push_ok, pop_ok;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    empty   = (cnt_q == '0);
    push_ok = push & ~full & ~flush;
    pop_ok  = pop & ~empty & ~flush;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = wr_q + AW'(push_ok);
      rd_d  = rd_q + AW'(pop_ok);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
    rdata = empty ? '0 : mem[rd_q];
    count = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end
endmodule

// File: rtl/fqi_sticky.sv
module fqi_sticky #(
  parameter int           N        = 3,
  parameter logic [N-1:0] COND_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  logic [N-1:0] sts_q, sts_d, cond_q, rise;

  always_comb begin
    rise  = cond & ~cond_q;
    // a fresh event beats a simultaneous clear
    sts_d = (sts_q & ~clr) | rise;
    sts   = sts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      cond_q <= COND_RST;
    end else begin
      sts_q  <= sts_d;
      cond_q <= cond;
    end
  end
endmodule

// File: rtl/fifo_irq_hub.sv
module fifo_irq_hub
  import fqi_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             ien_we,
  input  logic [REG_W-1:0] ien_wdata,
  output logic [REG_W-1:0] ien_rdata,
  input  logic             sts_we,
  input  logic [REG_W-1:0] sts_wdata,
  output logic [REG_W-1:0] sts_rdata,
  output logic [REG_W-1:0] lvl_rdata,
  input  logic             cpu_tx_push,
  input  logic [7:0]       cpu_tx_byte,
  input  logic             cpu_rx_pop,
  output logic [7:0]       cpu_rx_byte,
  input  logic             sh_tx_pop,
  output logic [7:0]       sh_tx_byte,
  input  logic             sh_rx_push,
  input  logic [7:0]       sh_rx_byte,
  input  logic             sh_xfer_done,
  output logic             irq
);
  localparam logic [CW-1:0] RX_HI = CW'((DEPTH * 3) / 4);
  localparam logic [CW-1:0] TX_LO = CW'(DEPTH / 4);
  // empty transmit queue already meets its threshold out of reset
  localparam logic [NUM_EVT-1:0] COND_RST = NUM_EVT'(1) << EVT_TX;

  logic [CW-1:0]      tx_cnt, rx_cnt;
  logic               tx_flush, rx_flush;
  logic [NUM_EVT-1:0] cond, clr, sts, en_q, en_d;

  assign tx_flush = ctl_we & ctl_wdata[CTL_TX_CLR];
  assign rx_flush = ctl_we & ctl_wdata[CTL_RX_CLR];

  fqi_byte_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(cpu_tx_push), .wdata(cpu_tx_byte),
    .pop(sh_tx_pop), .rdata(sh_tx_byte), .count(tx_cnt)
  );

  fqi_byte_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(sh_rx_push), .wdata(sh_rx_byte),
    .pop(cpu_rx_pop), .rdata(cpu_rx_byte), .count(rx_cnt)
  );

  always_comb begin
    cond           = '0;
    cond[EVT_RX]   = (rx_cnt >= RX_HI);
    cond[EVT_TX]   = (tx_cnt <= TX_LO);
    cond[EVT_DONE] = sh_xfer_done;
  end

  fqi_sticky #(.N(NUM_EVT), .COND_RST(COND_RST)) u_sticky (
    .clk(clk), .rst_n(rst_n), .cond(cond), .clr(clr), .sts(sts)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_map
    assign clr[g]  = sts_we & sts_wdata[evt_pos(g)];
    assign en_d[g] = ien_we ? ien_wdata[evt_pos(g)] : en_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    sts_rdata = '0;
    ien_rdata = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      sts_rdata[evt_pos(i)] = sts[i];
      ien_rdata[evt_pos(i)] = en_q[i];
    end
    lvl_rdata = '0;
    lvl_rdata[LVL_RX_LSB +: CW] = rx_cnt;
    lvl_rdata[LVL_TX_LSB +: CW] = tx_cnt;
    irq = |(sts & en_q);
  end

  logic unused_bits;
  assign unused_bits = ^{ctl_wdata, ien_wdata, sts_wdata};
endmodule

// File: rtl/fqi_checker.sv
module fqi_checker
  import fqi_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [REG_W-1:0] ctl_wdata,
  input logic             sts_we,
  input logic [REG_W-1:0] sts_wdata,
  input logic [REG_W-1:0] sts_rdata,
  input logic [REG_W-1:0] ien_rdata,
  input logic [REG_W-1:0] lvl_rdata,
  input logic             cpu_tx_push,
  input logic             sh_tx_pop,
  input logic             cpu_rx_pop,
  input logic [7:0]       cpu_rx_byte,
  input logic             irq
);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] RX_HI = CW'((DEPTH * 3) / 4);

  logic [CW-1:0] tx_c, rx_c;
  assign tx_c = lvl_rdata[LVL_TX_LSB +: CW];
  assign rx_c = lvl_rdata[LVL_RX_LSB +: CW];

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_c <= FULL) && (rx_c <= FULL));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_c == FULL && cpu_tx_push && !sh_tx_pop && !(ctl_we && ctl_wdata[CTL_TX_CLR]))
    |=> (tx_c == FULL));

  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_c == '0 && cpu_rx_pop) |-> (cpu_rx_byte == 8'h00));

  assert_tx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[CTL_TX_CLR]) |=> (tx_c == '0));

  assert_rx_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rdata[POS_RX]) |-> ($past(rx_c) >= RX_HI));

  assert_clear_by_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_rdata[POS_DONE]) |-> $past(sts_we && sts_wdata[POS_DONE]));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_rdata == '0) |-> !irq);

  logic unused_chk;
  assign unused_chk = ^{ctl_wdata, sts_wdata, sts_rdata, lvl_rdata};
endmodule

bind fifo_irq_hub fqi_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
  .ien_rdata(ien_rdata), .lvl_rdata(lvl_rdata),
  .cpu_tx_push(cpu_tx_push), .sh_tx_pop(sh_tx_pop),
  .cpu_rx_pop(cpu_rx_pop), .cpu_rx_byte(cpu_rx_byte), .irq(irq)
);

// File: tb/sim_fifo_irq_hub.sv
module sim_fifo_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 0, ien_we = 0, sts_we = 0;
  logic [31:0] ctl_wdata = 0, ien_wdata = 0, sts_wdata = 0;
  logic [31:0] ien_rdata, sts_rdata, lvl_rdata;
  logic        cpu_tx_push = 0, cpu_rx_pop = 0, sh_tx_pop = 0, sh_rx_push = 0;
  logic        sh_xfer_done = 0;
  logic [7:0]  cpu_tx_byte = 0, sh_rx_byte = 0;
  logic [7:0]  cpu_rx_byte, sh_tx_byte;
  logic        irq;

  int total = 0;
  int bad   = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #4 clk = ~clk;

  fifo_irq_hub u0 (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic cpu_push(input logic [7:0] b);
    cpu_tx_push = 1; cpu_tx_byte = b;
    if (txq.size() < 64) txq.push_back(b);
    tick(); cpu_tx_push = 0;
  endtask

  task automatic sh_push(input logic [7:0] b);
    sh_rx_push = 1; sh_rx_byte = b;
    if (rxq.size() < 64) rxq.push_back(b);
    tick(); sh_rx_push = 0;
  endtask

  task automatic sh_pop();
    sh_tx_pop = 1; tick(); sh_tx_pop = 0;
  endtask

  task automatic cpu_pop();
    cpu_rx_pop = 1; tick(); cpu_rx_pop = 0;
  endtask

  task automatic ctl_write(input logic [31:0] v);
    ctl_we = 1; ctl_wdata = v;
    if (v[8]) txq.delete();
    if (v[9]) rxq.delete();
    tick(); ctl_we = 0;
  endtask

  task automatic sts_clear(input logic [31:0] v);
    sts_we = 1; sts_wdata = v; tick(); sts_we = 0;
  endtask

  task automatic ien_write(input logic [31:0] v);
    ien_we = 1; ien_wdata = v; tick(); ien_we = 0;
  endtask

  // monitor: compares every byte leaving a queue with the scoreboard
  always @(negedge clk) begin
    logic [7:0] e;
    if (rst_n && sh_tx_pop) begin
      e = (txq.size() != 0) ? txq.pop_front() : 8'h00;
      check("R1/R3 tx byte", {24'h0, sh_tx_byte}, {24'h0, e});
    end
    if (rst_n && cpu_rx_pop) begin
      e = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
      check("R1/R3 rx byte", {24'h0, cpu_rx_byte}, {24'h0, e});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    // R10 reset state
    check("R10 level", lvl_rdata, 0);
    check("R10 status", sts_rdata, 0);
    check("R10 enable", ien_rdata, 0);
    check("R10 irq", {31'h0, irq}, 0);
    rst_n = 1;
    tick(3);
    check("R6 no event from reset", sts_rdata, 0);

    // transmit path and falling threshold (R1, R6)
    for (int i = 0; i < 20; i++) cpu_push(8'(8'h10 + i));
    check("R1 tx level field", lvl_rdata, 32'd20 << 16);
    for (int i = 0; i < 3; i++) sh_pop();
    tick();
    check("R6 count 17 no event", sts_rdata, 0);
    sh_pop(); tick();
    check("R6 count 16 event", sts_rdata, 32'h0000_1000);

    // enables and write-one-to-clear (R9, R8)
    ien_write(32'hFFFF_FFFF);
    check("R9 enable bits", ien_rdata, 32'h0001_1010);
    check("R9 irq on", {31'h0, irq}, 1);
    sts_clear(32'h0);
    check("R8 zero write keeps", sts_rdata, 32'h0000_1000);
    sts_clear(32'h0000_1000);
    check("R8 cleared", sts_rdata, 0);
    check("R9 irq off", {31'h0, irq}, 0);
    tick(3);
    check("R8 stays clear while true", sts_rdata, 0);
    ien_write(32'h0);

    // drain and empty read (R3)
    for (int i = 0; i < 16; i++) sh_pop();
    sh_pop();
    check("R3 tx level after empty read", lvl_rdata, 0);

    // overflow (R2)
    for (int i = 0; i < 65; i++) cpu_push(8'(8'h40 + i));
    check("R2 full count", lvl_rdata, 32'd64 << 16);
    for (int i = 0; i < 64; i++) sh_pop();
    sh_pop();
    check("R2 drained", lvl_rdata, 0);
    tick();
    sts_clear(32'hFFFF_FFFF);
    check("R8 all ones clears", sts_rdata, 0);

    // receive threshold (R5)
    for (int i = 0; i < 47; i++) sh_push(8'(8'hA0 + i));
    tick();
    check("R5 count 47 no event", sts_rdata, 0);
    sh_push(8'hEE); tick();
    check("R5 count 48 event", sts_rdata, 32'h0000_0010);
    check("R1 rx level field", lvl_rdata, 32'd48);

    // per-queue reset (R4)
    ctl_write(32'h0000_0100);
    check("R4 tx reset leaves rx", lvl_rdata, 32'd48);
    ctl_write(32'hFFFF_FCFF);
    check("R4 other bits no effect", lvl_rdata, 32'd48);
    for (int i = 0; i < 3; i++) cpu_pop();
    check("R1 rx after reads", lvl_rdata, 32'd45);
    ctl_write(32'h0000_0200);
    check("R4 rx reset", lvl_rdata, 0);
    cpu_pop();
    check("R3 rx level after empty read", lvl_rdata, 0);

    // transfer done (R7, R8)
    sh_xfer_done = 1; tick(2);
    check("R7 done event", sts_rdata, 32'h0001_0010);
    sts_clear(32'h0001_0000); tick(2);
    check("R7 held level no re-set", sts_rdata, 32'h0000_0010);
    sh_xfer_done = 0; tick();
    sh_xfer_done = 1; tick(); sh_xfer_done = 0; tick();
    check("R7 second pulse", sts_rdata, 32'h0001_0010);
    sh_xfer_done = 1; sts_we = 1; sts_wdata = 32'h0001_0000;
    tick(); sh_xfer_done = 0; sts_we = 0;
    check("R8 set wins over clear", sts_rdata, 32'h0001_0010);

    // masking (R9)
    ien_write(32'h0000_1000);
    check("R9 masked", {31'h0, irq}, 0);
    ien_write(32'h0000_0010);
    check("R9 rx enabled", {31'h0, irq}, 1);
    ien_write(32'h0001_0000);
    check("R9 done enabled", {31'h0, irq}, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule